// File: doc/BRIEF.md
# Pipelined Merged Multiply-Accumulate Unit

This block multiplies two signed two's-complement operands and adds the product to a running total in the same step. The new total is kept in carry-save form, so no carry-propagate adder sits in the accumulation loop. The operand is recoded into radix-4 digits, and one partial-product row is generated per digit. A carry-save tree then compresses those rows together with the stored total. The lower half of the result is resolved inside the first stage, and the last carry out of that lower half is kept as a separate bit. A second pipeline stage adds the stored upper sum and carry vectors in a carry-select adder and registers the full result. The feedback loop never passes through that adder, so the two stages work independently.

A two-state controller decides whether the stored total takes part in the next operation. In state `ST_EMPTY` the feedback rows are forced to zero. In state `ST_ACCUM` the feedback rows are used unless `clr` is high. The transitions are:
- Synchronous reset moves the controller to `ST_EMPTY`.
- An accepted operand (`in_valid`) moves it to `ST_ACCUM`. This transition is called T_LOAD.
- `clr` without `in_valid` moves it back to `ST_EMPTY`. This transition is called T_DROP.
- In all other cycles the state holds.

Because clearing is done by gating the feedback, the wide state registers never need to be zeroed.

Top module: `mac_merged`

## Requirements
- R1: For each accepted operand pair, `p` equals the previous total plus `a`×`b`. Both operands are signed two's complement, and the sum is taken modulo 2^(2N).
- R2: The result for operands sampled at clock edge k appears on `p` with `out_valid` high after edge k+1. Operands accepted on consecutive edges give results on consecutive edges.
- R3: `out_valid` is high after edge k+1 only if `in_valid` was sampled high at edge k. Each accepted operand pair produces exactly one result.
- R4: While `in_valid` is low and `clr` is low, the values on `a` and `b` have no effect, and the running total holds.
- R5: When `clr` and `in_valid` are sampled high together, the result is `a`×`b` alone.
- R6: When `clr` is sampled high with `in_valid` low, the running total is emptied and no result is issued. The next result is a plain product.
- R7: While `rst` is sampled high, `out_valid` is low after the edge. After reset the running total is empty.
- R8: While `out_valid` is low, `p` keeps its last value.
- R9: The extreme operands (-2^(N-1) and 2^(N-1)-1 in any pairing) give exact products. A total that passes 2^(2N-1) wraps modulo 2^(2N).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on `a`/`b` is accepted this cycle |
| clr | input | 1 | Discard the running total before this cycle's operation |
| a | input | N | Signed multiplicand |
| b | input | N | Signed multiplier, Booth-recoded |
| out_valid | output | 1 | `p` carries a new result |
| p | output | 2N | Accumulated result, modulo 2^(2N) |

## Verification
The bench builds the unit with N = 16 and a carry-select block width of 4. This gives eight Booth rows, an eleven-row compression tree and four select blocks, and a full 32-bit result whose wraparound is reached within a few operations of the most negative operand squared. With 16-bit operands a random stream covers every Booth digit value in every row position. The stream mixes gaps, clears and a mid-stream reset, so transitions T_LOAD and T_DROP occur from both states. The directed part hits the extreme-operand pairings and the clear-with-operand case.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_ACCUM = 1'b1
    } acc_state_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic clr,
    output logic fb_en
);

    acc_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_ACCUM;
            ST_ACCUM: if (clr && !in_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    always_comb begin
        fb_en = (state_q == ST_ACCUM) && !clr;
    end

endmodule

// File: rtl/mac_booth_pp.sv
module mac_booth_pp #(
    parameter int N = 16
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] pp_rows [N/2],
    output logic [2*N-1:0] neg_row
);

    localparam int W    = 2 * N;
    localparam int ROWS = N / 2;

    logic [ROWS-1:0] neg_dig;

    for (genvar j = 0; j < ROWS; j++) begin : g_digit
        logic d_hi, d_mid, d_lo;
        logic sel_one, sel_two;
        logic [N:0] mag, inv;

        assign d_hi  = b[2*j+1];
        assign d_mid = b[2*j];
        if (j == 0) begin : g_first
            assign d_lo = 1'b0;
        end else begin : g_rest
            assign d_lo = b[2*j-1];
        end

        assign sel_one    = d_mid ^ d_lo;
        assign sel_two    = (d_hi & ~d_mid & ~d_lo) | (~d_hi & d_mid & d_lo);
        assign neg_dig[j] = d_hi & ~(d_mid & d_lo);

        always_comb begin
            if (sel_one)      mag = {a[N-1], a};
            else if (sel_two) mag = {a, 1'b0};
            else              mag = '0;
            inv = neg_dig[j] ? ~mag : mag;
        end

        assign pp_rows[j] = {{(W-N-1){inv[N]}}, inv} << (2*j);
    end

    always_comb begin
        neg_row = '0;
        for (int j = 0; j < ROWS; j++) begin
            neg_row[2*j] = neg_dig[j];
        end
    end

endmodule

// File: rtl/mac_csa_tree.sv
module mac_csa_tree #(
    parameter int N = 16
) (
    input  logic [2*N-1:0] pp_rows [N/2],
    input  logic [2*N-1:0] neg_row,
    input  logic           fb_en,
    input  logic [N-1:0]   s_q,
    input  logic [N-1:0]   c_q,
    input  logic [N-1:0]   z_q,
    input  logic           k_q,
    output logic [N-1:0]   s_d,
    output logic [N-1:0]   c_d,
    output logic [N-1:0]   z_d,
    output logic           k_d
);

    localparam int W    = 2 * N;
    localparam int ROWS = N / 2;
    localparam int TOT  = ROWS + 3;

    logic [W-1:0] rows_in [TOT];
    logic [W-1:0] vec_sum, vec_car;
    logic [N:0]   low_res;

    always_comb begin
        for (int j = 0; j < ROWS; j++) rows_in[j] = pp_rows[j];
        rows_in[ROWS]   = neg_row | ({{(W-1){1'b0}}, fb_en & k_q} << N);
        rows_in[ROWS+1] = fb_en ? {s_q, z_q} : '0;
        rows_in[ROWS+2] = fb_en ? {c_q, {N{1'b0}}} : '0;
    end

    always_comb begin : reduce
        logic [W-1:0] cur [TOT];
        logic [W-1:0] nxt [TOT];
        int cnt, grp, rem;
        for (int r = 0; r < TOT; r++) cur[r] = rows_in[r];
        cnt = TOT;
        for (int lvl = 0; lvl < TOT; lvl++) begin
            if (cnt > 2) begin
                grp = cnt / 3;
                rem = cnt - 3 * grp;
                for (int r = 0; r < TOT; r++) nxt[r] = '0;
                for (int g = 0; g < TOT / 3; g++) begin
                    if (g < grp) begin
                        nxt[2*g]   = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
                        nxt[2*g+1] = ((cur[3*g] & cur[3*g+1]) |
                                      (cur[3*g] & cur[3*g+2]) |
                                      (cur[3*g+1] & cur[3*g+2])) << 1;
                    end
                end
                for (int r = 0; r < 2; r++) begin
                    if (r < rem) nxt[2*grp+r] = cur[3*grp+r];
                end
                for (int r = 0; r < TOT; r++) cur[r] = nxt[r];
                cnt = 2 * grp + rem;
            end
        end
        vec_sum = cur[0];
        vec_car = cur[1];
    end

    assign low_res = {1'b0, vec_sum[N-1:0]} + {1'b0, vec_car[N-1:0]};
    assign z_d = low_res[N-1:0];
    assign k_d = low_res[N];
    assign s_d = vec_sum[W-1:N];
    assign c_d = vec_car[W-1:N];

endmodule

// File: rtl/mac_csel_add.sv
module mac_csel_add #(
    parameter int N   = 16,
    parameter int BLK = 4
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic         cin,
    output logic [N-1:0] sum
);

    localparam int NB = N / BLK;

    logic [NB:0] carry;
    assign carry[0] = cin;

    for (genvar i = 0; i < NB; i++) begin : g_blk
        logic [BLK:0] r0, r1;
        assign r0 = {1'b0, x[i*BLK +: BLK]} + {1'b0, y[i*BLK +: BLK]};
        assign r1 = {1'b0, x[i*BLK +: BLK]} + {1'b0, y[i*BLK +: BLK]} + {{BLK{1'b0}}, 1'b1};
        assign sum[i*BLK +: BLK] = carry[i] ? r1[BLK-1:0] : r0[BLK-1:0];
        assign carry[i+1]        = carry[i] ? r1[BLK] : r0[BLK];
    end

endmodule

// File: rtl/mac_merged.sv
module mac_merged #(
    parameter int N   = 16,
    parameter int BLK = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           clr,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic           out_valid,
    output logic [2*N-1:0] p
);

    localparam int W    = 2 * N;
    localparam int ROWS = N / 2;

    logic           fb_en;
    logic [W-1:0]   pp_rows [ROWS];
    logic [W-1:0]   neg_row;
    logic [N-1:0]   s_d, c_d, z_d;
    logic           k_d;
    logic [N-1:0]   s_q, c_q, z_q;
    logic           k_q;
    logic           v1_q;
    logic [N-1:0]   hi_sum;

    mac_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .clr      (clr),
        .fb_en    (fb_en)
    );

    mac_booth_pp #(.N(N)) u_booth (
        .a       (a),
        .b       (b),
        .pp_rows (pp_rows),
        .neg_row (neg_row)
    );

    mac_csa_tree #(.N(N)) u_tree (
        .pp_rows (pp_rows),
        .neg_row (neg_row),
        .fb_en   (fb_en),
        .s_q     (s_q),
        .c_q     (c_q),
        .z_q     (z_q),
        .k_q     (k_q),
        .s_d     (s_d),
        .c_d     (c_d),
        .z_d     (z_d),
        .k_d     (k_d)
    );

    always_ff @(posedge clk) begin
        if (rst) v1_q <= 1'b0;
        else     v1_q <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst && in_valid) begin
            s_q <= s_d;
            c_q <= c_d;
            z_q <= z_d;
            k_q <= k_d;
        end
    end

    mac_csel_add #(.N(N), .BLK(BLK)) u_final (
        .x   (s_q),
        .y   (c_q),
        .cin (k_q),
        .sum (hi_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= v1_q;
            if (v1_q) p <= {hi_sum, z_q};
        end
    end

endmodule

// File: rtl/mac_merged_chk.sv
module mac_merged_chk #(
    parameter int N = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           clr,
    input logic [N-1:0]   a,
    input logic [N-1:0]   b,
    input logic           out_valid,
    input logic [2*N-1:0] p
);

    localparam int W = 2 * N;

    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= seen_q | out_valid;
    end

    function automatic logic [W-1:0] sx(input logic [N-1:0] v);
        return {{N{v[N-1]}}, v};
    endfunction

    // R2: an accepted operand gives a result two edges on
    p_result_latency_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    // R3: no result without an accepted operand
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    // R5: clear together with an operand gives the bare product
    p_clear_product_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && clr) |-> ##2 (p == sx($past(a, 2)) * sx($past(b, 2))));

    // R7: reset drops the valid flag
    p_reset_idle_r7: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R8: the result holds between valid cycles
    p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !out_valid) |-> $stable(p));

endmodule

bind mac_merged mac_merged_chk #(.N(N)) u_chk (.*);

// File: tb/mac_merged_tb.sv
`timescale 1ns/1ps
module mac_merged_tb;

    localparam int N = 16;
    localparam int W = 2 * N;

    logic           clk = 1'b0;
    logic           rst, in_valid, clr;
    logic [N-1:0]   a, b;
    logic           out_valid;
    logic [W-1:0]   p;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [W-1:0] acc;
    logic [W-1:0] q_val [$];
    int           q_cyc [$];
    string        q_tag [$];
    logic [W-1:0] last_p;
    bit           have_last = 0;

    always #2 clk = ~clk;

    mac_merged #(.N(N), .BLK(4)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .clr       (clr),
        .a         (a),
        .b         (b),
        .out_valid (out_valid),
        .p         (p)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] mul(input logic [N-1:0] x, input logic [N-1:0] y);
        longint pr;
        pr = longint'($signed(x)) * longint'($signed(y));
        return pr[W-1:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic op(input logic [N-1:0] x, input logic [N-1:0] y, input bit c, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        clr = c;
        a = x;
        b = y;
        if (c) acc = '0;
        acc = acc + mul(x, y);
        q_val.push_back(acc);
        q_cyc.push_back(cyc + 2);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int k, input bit c);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            clr = c && (i == 0);
            a = N'($urandom);
            b = N'($urandom);
            if (c && i == 0) acc = '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        clr = 1'b0;
        q_val.delete();
        q_cyc.delete();
        q_tag.delete();
        acc = '0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", W'(out_valid), '0);
        rst = 1'b0;
    endtask

    // result monitor, one nanosecond after each rising edge
    always @(posedge clk) begin
        #1;
        if (out_valid) begin
            if (q_val.size() == 0) begin
                chk(1'b0, "R3 or R6 unexpected result", p, '0);
            end else begin
                chk(p == q_val[0], q_tag[0], p, q_val[0]);
                chk(cyc == q_cyc[0], "R2 latency", W'(cyc), W'(q_cyc[0]));
                void'(q_val.pop_front());
                void'(q_cyc.pop_front());
                void'(q_tag.pop_front());
            end
            last_p = p;
            have_last = 1;
        end else begin
            if (q_cyc.size() != 0 && q_cyc[0] <= cyc)
                chk(1'b0, "R2 missing result", '0, q_val[0]);
            if (have_last)
                chk(p == last_p, "R8 hold", p, last_p);
        end
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        rst = 1'b1;
        in_valid = 1'b0;
        clr = 1'b0;
        a = '0;
        b = '0;
        acc = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R7 reset state", W'(out_valid), '0);
        rst = 1'b0;

        op(16'h7fff, 16'h7fff, 1'b1, "R5 clear with operand");
        op(16'h8000, 16'h8000, 1'b0, "R9 min times min");
        op(16'h8000, 16'h8000, 1'b0, "R9 wrap past sign");
        op(16'h8000, 16'h7fff, 1'b0, "R9 min times max");
        op(16'hffff, 16'h0001, 1'b0, "R1 minus one");
        idle(3, 1'b0);
        op(16'h0003, 16'hfffd, 1'b0, "R4 idle inputs ignored");
        idle(1, 1'b1);
        idle(2, 1'b0);
        op(16'h1234, 16'h5678, 1'b0, "R6 clear alone");
        op(16'h0100, 16'h0100, 1'b0, "R1 back to back");
        op(16'h8000, 16'h8000, 1'b1, "R5 clear min squared");
        do_reset();
        op(16'h0002, 16'h0003, 1'b0, "R7 empty after reset");

        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 4 == 0)
                idle(1, ($urandom % 16) == 0);
            else
                op(N'($urandom), N'($urandom), ($urandom % 32) == 0, "R1 random stream");
        end

        idle(6, 1'b0);
        chk(q_val.size() == 0, "R2 all results delivered", W'(q_val.size()), '0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule